// File: doc/BRIEF.md
# Error Severity and Message Gating

This block sits beside the error detectors of a link endpoint or switch port. It takes one detected error per cycle, given as a status vector with one bit set, a flag saying the error is correctable and a flag saying an uncorrectable error may be downgraded to an advisory report. From these it decides the error's class and severity. It records the error in sticky correctable, uncorrectable and device-level status bits. It then applies the mask, severity and reporting-enable inputs to decide two things: whether an error message goes out and with which severity code, and whether the header-capture logic next to the block should record the error.

A second, independent path applies the checks a bridge stage makes on an error message arriving from below before passing it upward. These are the bridge-control system-error enable and then the ordinary device-level system-error and severity enables. The path records the received and signalled system-error status bits as it goes. Header capture and root-side collection are outside the block and connect through the strobes it produces.

Top module: `err_report_gate`

## Requirements
- R1: The event status is ANDed with the supported bits of its class (correctable: bits 0, 6, 7, 8, 12, 13, 14, 15; uncorrectable: bits 0, 4, 5 and 12 to 25). If the result does not have exactly one bit set, the event changes no status, sends no message and requests no log, and `ev_reject` pulses instead.
- R2: `dev_status` holds four sticky flags. Bit 0 is set by any correctable report, including an advisory one. Bit 1 is set by a non-fatal uncorrectable error and bit 2 by a fatal one. Bit 3 is set when the error is an uncorrectable unsupported request (bit 20).
- R3: A correctable error sets its bit in `cor_status`, and the bit stays set. When the same bit of `cor_mask` is set, no message is sent.
- R4: A correctable message (code 1) needs `cor_rep_en`. If the report comes from an unsupported request, it also needs `ur_rep_en`.
- R5: With `SEV_FROM_REG` = 1, an uncorrectable error is fatal when its bit in `unc_sev` is set. With `SEV_FROM_REG` = 0, it is fatal only for bits 0, 4, 5, 13, 17 and 18.
- R6: A non-fatal uncorrectable error with `ev_adv` set is reported as correctable bit 13. If `cor_mask` bit 13 is set, nothing further happens. Otherwise its `unc_status` bit is set and a correctable message is decided per R4, but a log is requested only if its `unc_mask` bit is clear. A fatal error with `ev_adv` set is not downgraded.
- R7: An uncorrectable error sets its sticky `unc_status` bit even when `unc_mask` masks it. A masked error sends no message and requests no log.
- R8: An unmasked uncorrectable error requests a log, with `log_bit` equal to its one-hot bit. A fatal message (code 3) needs `serr_en` or `fat_rep_en`. A non-fatal message (code 2) needs `serr_en` or `nf_rep_en`.
- R9: An uncorrectable unsupported request sends no message while `ur_rep_en` and `serr_en` are both low.
- R10: `msg_valid`, `msg_sev`, `log_req`, `log_bit` and `ev_reject` are single-cycle strobes registered one cycle after `ev_valid`. After reset every output is zero.
- R11: An incoming message with code 2 or 3 sets sticky `sec_rcv_serr`. It goes no further unless `bridge_serr_en` is set.
- R12: After passing the bridge check, an uncorrectable message with `serr_en` set sets sticky `sig_serr`. It is forwarded one cycle later only if the matching severity enable (`fat_rep_en` or `nf_rep_en`) is set. Correctable messages are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An error event is presented this cycle |
| ev_status | input | 32 | Error bit of the event (one-hot expected) |
| ev_cor | input | 1 | Event belongs to the correctable class |
| ev_adv | input | 1 | Uncorrectable event may be downgraded to advisory |
| unc_mask | input | 32 | Uncorrectable mask bits |
| unc_sev | input | 32 | Uncorrectable severity bits (1 = fatal) |
| cor_mask | input | 32 | Correctable mask bits |
| serr_en | input | 1 | Device system-error enable |
| cor_rep_en | input | 1 | Correctable reporting enable |
| nf_rep_en | input | 1 | Non-fatal reporting enable |
| fat_rep_en | input | 1 | Fatal reporting enable |
| ur_rep_en | input | 1 | Unsupported-request reporting enable |
| bridge_serr_en | input | 1 | Bridge-control system-error forwarding enable |
| up_valid | input | 1 | Message arriving from below |
| up_sev | input | 2 | Severity code of the arriving message |
| cor_status | output | 32 | Sticky correctable status |
| unc_status | output | 32 | Sticky uncorrectable status |
| dev_status | output | 4 | Sticky device flags: correctable, non-fatal, fatal, unsupported request |
| msg_valid | output | 1 | Error message strobe |
| msg_sev | output | 2 | Message severity: 0 none, 1 correctable, 2 non-fatal, 3 fatal |
| log_req | output | 1 | Header capture request strobe |
| log_bit | output | 32 | One-hot error bit for the capture request |
| ev_reject | output | 1 | Event rejected as malformed |
| fwd_valid | output | 1 | Forwarded message strobe |
| fwd_sev | output | 2 | Forwarded message severity |
| sec_rcv_serr | output | 1 | Sticky received-system-error flag |
| sig_serr | output | 1 | Sticky signalled-system-error flag |

## Verification
A wrong classification shows up in the very next cycle. It appears as the wrong `msg_sev` code, a missing or extra `log_req`, or a status bit set in the wrong register. Because all status is sticky, a bit set in error stays visible on `cor_status`, `unc_status` or `dev_status` for the rest of the run. A later check therefore also exposes an earlier mistake. A faulty enable or mask term in the forwarding path appears one cycle after `up_valid`, on `fwd_valid` or on the two sticky system-error flags.

// File: rtl/err_gate_pkg.sv
package err_gate_pkg;

  localparam int STS_W = 32;
  localparam int DEV_W = 4;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'd0,
    SEV_COR      = 2'd1,
    SEV_NONFATAL = 2'd2,
    SEV_FATAL    = 2'd3
  } sev_e;

  // positions whose meaning other logic depends on
  localparam int UNC_UR_POS  = 20;
  localparam int COR_ADV_POS = 13;

  localparam logic [STS_W-1:0] UNC_SUPP_DEF  = 32'h03FF_F031;
  localparam logic [STS_W-1:0] COR_SUPP_DEF  = 32'h0000_F1C1;
  localparam logic [STS_W-1:0] UNC_FATAL_DEF = 32'h0006_2031;
  localparam logic [STS_W-1:0] COR_ADV_BIT   = STS_W'(1) << COR_ADV_POS;

  // device status flag positions
  localparam int DS_COR = 0;
  localparam int DS_NF  = 1;
  localparam int DS_FAT = 2;
  localparam int DS_UR  = 3;

  function automatic logic single_bit(input logic [STS_W-1:0] v);
    return (v != '0) && ((v & (v - STS_W'(1))) == '0);
  endfunction

  function automatic logic is_uncor(input logic [1:0] code);
    return (code == SEV_NONFATAL) || (code == SEV_FATAL);
  endfunction

endpackage

// File: rtl/err_gate_classify.sv
module err_gate_classify
  import err_gate_pkg::*;
#(
  parameter logic [STS_W-1:0] UNC_SUPP     = UNC_SUPP_DEF,
  parameter logic [STS_W-1:0] COR_SUPP     = COR_SUPP_DEF,
  parameter logic [STS_W-1:0] UNC_FATAL    = UNC_FATAL_DEF,
  parameter bit               SEV_FROM_REG = 1'b1
) (
  input  logic [STS_W-1:0] ev_status,
  input  logic             ev_cor,
  input  logic             ev_adv,
  input  logic [STS_W-1:0] unc_sev,
  output logic [STS_W-1:0] bit_vec,
  output logic             ok,
  output logic             is_ur,
  output logic             is_fatal,
  output logic             take_adv,
  output logic             cor_path
);

  logic [STS_W-1:0] fatal_map;

  // per-bit choice between register-driven and fixed severity
  for (genvar g = 0; g < STS_W; g++) begin : g_sev
    if (SEV_FROM_REG) begin : g_reg
      assign fatal_map[g] = unc_sev[g];
    end else begin : g_fix
      assign fatal_map[g] = UNC_FATAL[g] | (unc_sev[g] & 1'b0);
    end
  end

  assign bit_vec  = ev_status & (ev_cor ? COR_SUPP : UNC_SUPP);
  assign ok       = single_bit(bit_vec);
  assign is_ur    = !ev_cor && bit_vec[UNC_UR_POS];
  assign is_fatal = !ev_cor && ((bit_vec & fatal_map) != '0);
  assign take_adv = !ev_cor && !is_fatal && ev_adv;
  assign cor_path = ev_cor || take_adv;

endmodule

// File: rtl/err_gate_decide.sv
module err_gate_decide
  import err_gate_pkg::*;
(
  input  logic             ev_valid,
  input  logic             ev_cor,
  input  logic [STS_W-1:0] bit_vec,
  input  logic             ok,
  input  logic             is_ur,
  input  logic             is_fatal,
  input  logic             take_adv,
  input  logic             cor_path,
  input  logic [STS_W-1:0] unc_mask,
  input  logic [STS_W-1:0] cor_mask,
  input  logic             serr_en,
  input  logic             cor_rep_en,
  input  logic             nf_rep_en,
  input  logic             fat_rep_en,
  input  logic             ur_rep_en,
  output logic [DEV_W-1:0] dev_set,
  output logic [STS_W-1:0] cor_set,
  output logic [STS_W-1:0] unc_set,
  output logic             send,
  output logic [1:0]       sev,
  output logic             log,
  output logic             reject
);

  logic [STS_W-1:0] cor_bit;
  assign cor_bit = ev_cor ? bit_vec : COR_ADV_BIT;

  always_comb begin
    dev_set = '0;
    cor_set = '0;
    unc_set = '0;
    send    = 1'b0;
    sev     = SEV_NONE;
    log     = 1'b0;
    reject  = ev_valid && !ok;
    if (ev_valid && ok) begin
      if (cor_path) begin
        dev_set[DS_COR] = 1'b1;
        dev_set[DS_UR]  = is_ur;
        cor_set         = cor_bit;
        if ((cor_mask & cor_bit) == '0) begin
          if (take_adv) begin
            unc_set = bit_vec;
            log     = ((unc_mask & bit_vec) == '0);
          end
          send = cor_rep_en && (!is_ur || ur_rep_en);
          sev  = send ? SEV_COR : SEV_NONE;
        end
      end else begin
        dev_set[DS_FAT] = is_fatal;
        dev_set[DS_NF]  = !is_fatal;
        dev_set[DS_UR]  = is_ur;
        unc_set         = bit_vec;
        if ((unc_mask & bit_vec) == '0) begin
          log = 1'b1;
          if (is_ur && !ur_rep_en && !serr_en) begin
            send = 1'b0;
          end else if (is_fatal) begin
            send = serr_en || fat_rep_en;
          end else begin
            send = serr_en || nf_rep_en;
          end
          if (send) sev = is_fatal ? SEV_FATAL : SEV_NONFATAL;
        end
      end
    end
  end

endmodule

// File: rtl/err_gate_fwd.sv
module err_gate_fwd
  import err_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_valid,
  input  logic [1:0] up_sev,
  input  logic       bridge_serr_en,
  input  logic       serr_en,
  input  logic       nf_rep_en,
  input  logic       fat_rep_en,
  output logic       fwd_valid,
  output logic [1:0] fwd_sev,
  output logic       sec_rcv_serr,
  output logic       sig_serr
);

  logic up_uncor, pass_bridge, pass_dev, sev_ok;

  assign up_uncor    = up_valid && is_uncor(up_sev);
  assign pass_bridge = up_uncor && bridge_serr_en;
  assign pass_dev    = pass_bridge && serr_en;
  assign sev_ok      = (up_sev == SEV_FATAL) ? fat_rep_en : nf_rep_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid    <= 1'b0;
      fwd_sev      <= SEV_NONE;
      sec_rcv_serr <= 1'b0;
      sig_serr     <= 1'b0;
    end else begin
      fwd_valid <= pass_dev && sev_ok;
      fwd_sev   <= (pass_dev && sev_ok) ? up_sev : SEV_NONE;
      if (up_uncor) sec_rcv_serr <= 1'b1;
      if (pass_dev) sig_serr     <= 1'b1;
    end
  end

endmodule

// File: rtl/err_report_gate.sv
module err_report_gate
  import err_gate_pkg::*;
#(
  parameter logic [STS_W-1:0] UNC_SUPP     = UNC_SUPP_DEF,
  parameter logic [STS_W-1:0] COR_SUPP     = COR_SUPP_DEF,
  parameter logic [STS_W-1:0] UNC_FATAL    = UNC_FATAL_DEF,
  parameter bit               SEV_FROM_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [STS_W-1:0] ev_status,
  input  logic             ev_cor,
  input  logic             ev_adv,
  input  logic [STS_W-1:0] unc_mask,
  input  logic [STS_W-1:0] unc_sev,
  input  logic [STS_W-1:0] cor_mask,
  input  logic             serr_en,
  input  logic             cor_rep_en,
  input  logic             nf_rep_en,
  input  logic             fat_rep_en,
  input  logic             ur_rep_en,
  input  logic             bridge_serr_en,
  input  logic             up_valid,
  input  logic [1:0]       up_sev,
  output logic [STS_W-1:0] cor_status,
  output logic [STS_W-1:0] unc_status,
  output logic [DEV_W-1:0] dev_status,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic             log_req,
  output logic [STS_W-1:0] log_bit,
  output logic             ev_reject,
  output logic             fwd_valid,
  output logic [1:0]       fwd_sev,
  output logic             sec_rcv_serr,
  output logic             sig_serr
);

  // classification results, named for the checker
  logic [STS_W-1:0] bit_vec;
  logic             cls_ok, cls_ur, cls_fatal, cls_adv, cls_cor_path;

  // decision results
  logic [DEV_W-1:0] dev_set;
  logic [STS_W-1:0] cor_set, unc_set;
  logic             dec_send, dec_log, dec_reject;
  logic [1:0]       dec_sev;

  err_gate_classify #(
    .UNC_SUPP(UNC_SUPP), .COR_SUPP(COR_SUPP),
    .UNC_FATAL(UNC_FATAL), .SEV_FROM_REG(SEV_FROM_REG)
  ) u_cls (
    .ev_status(ev_status), .ev_cor(ev_cor), .ev_adv(ev_adv),
    .unc_sev(unc_sev), .bit_vec(bit_vec), .ok(cls_ok),
    .is_ur(cls_ur), .is_fatal(cls_fatal), .take_adv(cls_adv),
    .cor_path(cls_cor_path)
  );

  err_gate_decide u_dec (
    .ev_valid(ev_valid), .ev_cor(ev_cor), .bit_vec(bit_vec),
    .ok(cls_ok), .is_ur(cls_ur), .is_fatal(cls_fatal),
    .take_adv(cls_adv), .cor_path(cls_cor_path),
    .unc_mask(unc_mask), .cor_mask(cor_mask), .serr_en(serr_en),
    .cor_rep_en(cor_rep_en), .nf_rep_en(nf_rep_en),
    .fat_rep_en(fat_rep_en), .ur_rep_en(ur_rep_en),
    .dev_set(dev_set), .cor_set(cor_set), .unc_set(unc_set),
    .send(dec_send), .sev(dec_sev), .log(dec_log), .reject(dec_reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_status <= '0;
      unc_status <= '0;
      dev_status <= '0;
      msg_valid  <= 1'b0;
      msg_sev    <= SEV_NONE;
      log_req    <= 1'b0;
      log_bit    <= '0;
      ev_reject  <= 1'b0;
    end else begin
      cor_status <= cor_status | cor_set;
      unc_status <= unc_status | unc_set;
      dev_status <= dev_status | dev_set;
      msg_valid  <= dec_send;
      msg_sev    <= dec_sev;
      log_req    <= dec_log;
      log_bit    <= dec_log ? bit_vec : '0;
      ev_reject  <= dec_reject;
    end
  end

  err_gate_fwd u_fwd (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_sev(up_sev),
    .bridge_serr_en(bridge_serr_en), .serr_en(serr_en),
    .nf_rep_en(nf_rep_en), .fat_rep_en(fat_rep_en),
    .fwd_valid(fwd_valid), .fwd_sev(fwd_sev),
    .sec_rcv_serr(sec_rcv_serr), .sig_serr(sig_serr)
  );

endmodule

// File: rtl/err_report_gate_chk.sv
module err_report_gate_chk
  import err_gate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_reject,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic             log_req,
  input logic [STS_W-1:0] log_bit,
  input logic [STS_W-1:0] unc_mask,
  input logic [STS_W-1:0] cor_status,
  input logic [STS_W-1:0] unc_status,
  input logic             up_valid,
  input logic             bridge_serr_en,
  input logic             fwd_valid,
  input logic [1:0]       fwd_sev
);

  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |-> (!msg_valid && !log_req));

  p_msg_follows_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || log_req || ev_reject) |-> $past(ev_valid));

  p_msg_has_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != SEV_NONE));

  p_log_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(log_bit) == 1));

  p_log_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ((log_bit & $past(unc_mask)) == '0));

  p_cor_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cor_status & $past(cor_status)) == $past(cor_status)));

  p_unc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((unc_status & $past(unc_status)) == $past(unc_status)));

  p_fwd_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(up_valid && bridge_serr_en));

  p_fwd_uncor_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_sev == SEV_FATAL || fwd_sev == SEV_NONFATAL));

endmodule

bind err_report_gate err_report_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_reject(ev_reject),
  .msg_valid(msg_valid), .msg_sev(msg_sev), .log_req(log_req),
  .log_bit(log_bit), .unc_mask(unc_mask), .cor_status(cor_status),
  .unc_status(unc_status), .up_valid(up_valid),
  .bridge_serr_en(bridge_serr_en), .fwd_valid(fwd_valid), .fwd_sev(fwd_sev)
);

// File: tb/err_report_gate_test.sv
`timescale 1ns/1ps
module err_report_gate_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ev_valid = 0, ev_cor = 0, ev_adv = 0;
  logic [31:0] ev_status = 0, unc_mask = 0, unc_sev = 0, cor_mask = 0;
  logic        serr_en = 0, cor_rep_en = 0, nf_rep_en = 0, fat_rep_en = 0;
  logic        ur_rep_en = 0, bridge_serr_en = 0, up_valid = 0;
  logic [1:0]  up_sev = 0;

  logic [31:0] cor_status, unc_status, log_bit;
  logic [3:0]  dev_status;
  logic        msg_valid, log_req, ev_reject, fwd_valid, sec_rcv_serr, sig_serr;
  logic [1:0]  msg_sev, fwd_sev;

  logic [31:0] d_cor_status, d_unc_status, d_log_bit;
  logic [3:0]  d_dev_status;
  logic        d_msg_valid, d_log_req, d_ev_reject, d_fwd_valid, d_sec, d_sig;
  logic [1:0]  d_msg_sev, d_fwd_sev;

  err_report_gate uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_status(ev_status),
    .ev_cor(ev_cor), .ev_adv(ev_adv), .unc_mask(unc_mask), .unc_sev(unc_sev),
    .cor_mask(cor_mask), .serr_en(serr_en), .cor_rep_en(cor_rep_en),
    .nf_rep_en(nf_rep_en), .fat_rep_en(fat_rep_en), .ur_rep_en(ur_rep_en),
    .bridge_serr_en(bridge_serr_en), .up_valid(up_valid), .up_sev(up_sev),
    .cor_status(cor_status), .unc_status(unc_status), .dev_status(dev_status),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .log_req(log_req),
    .log_bit(log_bit), .ev_reject(ev_reject), .fwd_valid(fwd_valid),
    .fwd_sev(fwd_sev), .sec_rcv_serr(sec_rcv_serr), .sig_serr(sig_serr)
  );

  err_report_gate #(.SEV_FROM_REG(1'b0)) uut_dflt (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_status(ev_status),
    .ev_cor(ev_cor), .ev_adv(ev_adv), .unc_mask(unc_mask), .unc_sev(unc_sev),
    .cor_mask(cor_mask), .serr_en(serr_en), .cor_rep_en(cor_rep_en),
    .nf_rep_en(nf_rep_en), .fat_rep_en(fat_rep_en), .ur_rep_en(ur_rep_en),
    .bridge_serr_en(bridge_serr_en), .up_valid(up_valid), .up_sev(up_sev),
    .cor_status(d_cor_status), .unc_status(d_unc_status),
    .dev_status(d_dev_status), .msg_valid(d_msg_valid), .msg_sev(d_msg_sev),
    .log_req(d_log_req), .log_bit(d_log_bit), .ev_reject(d_ev_reject),
    .fwd_valid(d_fwd_valid), .fwd_sev(d_fwd_sev), .sec_rcv_serr(d_sec),
    .sig_serr(d_sig)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model for uut (severity taken from unc_sev)
  logic [31:0] m_cor, m_unc, m_lbit, sel, cb;
  logic [3:0]  m_dev;
  logic        m_msg, m_log, m_rej, m_fwd, m_rcv, m_sig, m_ur, m_fat;
  logic [1:0]  m_sev, m_fsev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cor = 0; m_unc = 0; m_dev = 0; m_msg = 0; m_sev = 0; m_log = 0;
      m_lbit = 0; m_rej = 0; m_fwd = 0; m_fsev = 0; m_rcv = 0; m_sig = 0;
    end else begin
      m_msg = 0; m_sev = 0; m_log = 0; m_lbit = 0; m_rej = 0;
      if (ev_valid) begin
        sel = ev_status & (ev_cor ? 32'h0000F1C1 : 32'h03FFF031);
        if ($countones(sel) != 1) m_rej = 1;
        else begin
          m_ur  = !ev_cor && sel[20];
          m_fat = !ev_cor && ((sel & unc_sev) != 0);
          if (ev_cor || (ev_adv && !m_fat)) begin
            cb = ev_cor ? sel : 32'h0000_2000;
            m_dev[0] = 1; if (m_ur) m_dev[3] = 1;
            m_cor = m_cor | cb;
            if ((cor_mask & cb) == 0) begin
              if (!ev_cor) begin
                m_unc = m_unc | sel;
                if ((unc_mask & sel) == 0) begin m_log = 1; m_lbit = sel; end
              end
              if (cor_rep_en && (!m_ur || ur_rep_en)) begin m_msg = 1; m_sev = 1; end
            end
          end else begin
            if (m_fat) m_dev[2] = 1; else m_dev[1] = 1;
            if (m_ur) m_dev[3] = 1;
            m_unc = m_unc | sel;
            if ((unc_mask & sel) == 0) begin
              m_log = 1; m_lbit = sel;
              if (!(m_ur && !ur_rep_en && !serr_en) &&
                  (m_fat ? (serr_en || fat_rep_en) : (serr_en || nf_rep_en))) begin
                m_msg = 1; m_sev = m_fat ? 2'd3 : 2'd2;
              end
            end
          end
        end
      end
      m_fwd = 0; m_fsev = 0;
      if (up_valid && (up_sev == 2'd2 || up_sev == 2'd3)) begin
        m_rcv = 1;
        if (bridge_serr_en && serr_en) begin
          m_sig = 1;
          if (up_sev == 2'd3 ? fat_rep_en : nf_rep_en) begin m_fwd = 1; m_fsev = up_sev; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R1 model reject", 32'(ev_reject), 32'(m_rej));
      chk("R2 model dev_status", 32'(dev_status), 32'(m_dev));
      chk("R3 model cor_status", cor_status, m_cor);
      chk("R7 model unc_status", unc_status, m_unc);
      chk("R4 model msg_valid", 32'(msg_valid), 32'(m_msg));
      chk("R8 model msg_sev", 32'(msg_sev), 32'(m_sev));
      chk("R8 model log", {log_bit[30:0], log_req}, {m_lbit[30:0], m_log});
      chk("R12 model fwd", {28'd0, fwd_sev, fwd_valid, sig_serr}, {28'd0, m_fsev, m_fwd, m_sig});
      chk("R11 model sec_rcv", 32'(sec_rcv_serr), 32'(m_rcv));
    end
  end

  task automatic pulse(input logic [31:0] st, input logic c, input logic a);
    @(negedge clk);
    ev_status = st; ev_cor = c; ev_adv = a; ev_valid = 1;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic fpulse(input logic [1:0] s);
    @(negedge clk);
    up_sev = s; up_valid = 1;
    @(negedge clk);
    up_valid = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] keep;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_on = 1;
    // R10 reset state
    chk("R10 reset msg", 32'(msg_valid), 0);
    chk("R10 reset cor", cor_status, 0);
    chk("R10 reset unc", unc_status, 0);
    chk("R10 reset dev", 32'(dev_status), 0);
    chk("R10 reset fwd", 32'(fwd_valid), 0);

    // correctable path
    cor_rep_en = 1;
    pulse(32'h40, 1, 0);
    chk("R4 cor msg", {30'd0, msg_sev}, 1);
    chk("R3 cor bit6", 32'(cor_status[6]), 1);
    chk("R2 cor flag", 32'(dev_status[0]), 1);
    @(negedge clk);
    chk("R10 single pulse", 32'(msg_valid), 0);
    cor_mask = 32'h80;
    pulse(32'h80, 1, 0);
    chk("R3 masked cor msg", 32'(msg_valid), 0);
    chk("R3 masked cor status", 32'(cor_status[7]), 1);
    cor_rep_en = 0;
    pulse(32'h1, 1, 0);
    chk("R4 cor disabled", 32'(msg_valid), 0);
    cor_rep_en = 1;

    // malformed events
    keep = cor_status;
    pulse(32'h41, 1, 0);
    chk("R1 two bits reject", 32'(ev_reject), 1);
    chk("R1 two bits no msg", 32'(msg_valid), 0);
    chk("R1 status untouched", cor_status, keep);
    pulse(32'h2, 1, 0);
    chk("R1 unsupported cor bit", 32'(ev_reject), 1);
    keep = unc_status;
    pulse(32'h2, 0, 0);
    chk("R1 unsupported unc bit", 32'(ev_reject), 1);
    chk("R1 unc untouched", unc_status, keep);

    // uncorrectable severities
    nf_rep_en = 1;
    pulse(32'h1000, 0, 0);
    chk("R8 nonfatal msg", {30'd0, msg_sev}, 2);
    chk("R8 log bit", log_bit, 32'h1000);
    chk("R2 nonfatal flag", 32'(dev_status[1]), 1);
    chk("R5 default nonfatal", {30'd0, d_msg_sev}, 2);
    unc_sev = 32'h10;
    pulse(32'h10, 0, 0);
    chk("R8 fatal gated", 32'(msg_valid), 0);
    chk("R8 fatal logged", 32'(log_req), 1);
    chk("R2 fatal flag", 32'(dev_status[2]), 1);
    serr_en = 1;
    pulse(32'h10, 0, 0);
    chk("R8 fatal via serr", {30'd0, msg_sev}, 3);
    serr_en = 0; fat_rep_en = 1; unc_sev = 0;
    pulse(32'h1, 0, 0);
    chk("R5 reg severity", {30'd0, msg_sev}, 2);
    chk("R5 default severity", {30'd0, d_msg_sev}, 3);

    // masking
    unc_mask = 32'h4000;
    pulse(32'h4000, 0, 0);
    chk("R7 masked no msg", 32'(msg_valid), 0);
    chk("R7 masked no log", 32'(log_req), 0);
    chk("R7 masked status", 32'(unc_status[14]), 1);

    // unsupported request
    pulse(32'h100000, 0, 0);
    chk("R9 ur blocked", 32'(msg_valid), 0);
    chk("R9 ur logged", 32'(log_req), 1);
    chk("R2 ur flag", 32'(dev_status[3]), 1);
    ur_rep_en = 1;
    pulse(32'h100000, 0, 0);
    chk("R9 ur enabled", {30'd0, msg_sev}, 2);

    // advisory demotion
    unc_mask = 32'h10000;
    pulse(32'h8000, 0, 1);
    chk("R6 adv cor msg", {30'd0, msg_sev}, 1);
    chk("R6 adv cor bit13", 32'(cor_status[13]), 1);
    chk("R6 adv unc bit", 32'(unc_status[15]), 1);
    chk("R6 adv log", log_bit, 32'h8000);
    pulse(32'h10000, 0, 1);
    chk("R6 adv masked no log", 32'(log_req), 0);
    chk("R6 adv masked status", 32'(unc_status[16]), 1);
    chk("R6 adv masked msg", 32'(msg_valid), 1);
    cor_mask = 32'h2080;
    pulse(32'h80000, 0, 1);
    chk("R6 adv cor-masked msg", 32'(msg_valid), 0);
    chk("R6 adv cor-masked unc", 32'(unc_status[19]), 0);
    unc_sev = 32'h10;
    pulse(32'h10, 0, 1);
    chk("R6 fatal not demoted", {30'd0, msg_sev}, 3);
    cor_mask = 0; ur_rep_en = 0;
    pulse(32'h100000, 0, 1);
    chk("R4 adv ur needs ur enable", 32'(msg_valid), 0);

    // forwarding stage
    serr_en = 1; bridge_serr_en = 0;
    fpulse(2'd2);
    chk("R11 bridge blocks", 32'(fwd_valid), 0);
    chk("R11 received flag", 32'(sec_rcv_serr), 1);
    chk("R11 no signalled", 32'(sig_serr), 0);
    bridge_serr_en = 1; serr_en = 0;
    fpulse(2'd2);
    chk("R12 serr off", 32'(fwd_valid), 0);
    chk("R12 serr off flag", 32'(sig_serr), 0);
    serr_en = 1;
    fpulse(2'd2);
    chk("R12 forward nonfatal", {30'd0, fwd_sev}, 2);
    chk("R12 signalled flag", 32'(sig_serr), 1);
    fpulse(2'd1);
    chk("R12 cor not forwarded", 32'(fwd_valid), 0);
    fat_rep_en = 0;
    fpulse(2'd3);
    chk("R12 fatal disabled", 32'(fwd_valid), 0);
    fat_rep_en = 1;
    fpulse(2'd3);
    chk("R12 forward fatal", {30'd0, fwd_sev}, 3);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule